// File: doc/BRIEF.md
# Multiplexed Burst Bus Controller

This block sits between a core's load/store port and an external bus whose address and data share one set of pins. The core pushes requests of one to four 32-bit words into a three-entry queue. The core can keep issuing requests while earlier ones are still on the bus. The controller takes the oldest request and drives a bus cycle. The cycle starts with a one-clock address phase marked by an address latch strobe. Data phases follow on the same pins. An idle or recovery cycle comes after the last data phase.

The top address bits select one of several memory regions, and a 2-bit width code per region sets the physical bus width to 8, 16 or 32 bits. A 32-bit word is split into narrower beats on a narrow region. An external ready input stretches the cycle at three points: before the first data beat, between beats, and before the next address. A byte-order input chooses little or big endian lane steering. Read words are reassembled and returned with a one-cycle valid pulse.

Top module: `mbb_bus_ctrl`

## Requirements
- R1: The queue holds up to three requests. `reqFull` is high exactly while three are held, and a request is accepted on a rising edge where `reqValid` is high and `reqFull` is low. Requests go to the bus in the order they were accepted.
- R2: When the controller is idle, the address phase occurs in the second cycle after the edge that accepts a request. During that cycle `busAle` is high for exactly one clock, `busAdOe` is high and `busAdOut` equals the request address.
- R3: The region index is `addr[31:29]`, and the width code is `regionWidth[2*index+1 : 2*index]`. Code 00 selects an 8-bit bus, 01 a 16-bit bus, and 10 or 11 a 32-bit bus.
- R4: A request with length code `reqLen` carries `reqLen+1` words. Each word takes 4, 2 or 1 beats on an 8-, 16- or 32-bit region.
- R5: A data beat completes only on a rising edge where `busRdy` is high. While `busRdy` is low in a data phase, the write data on the pins holds steady, and this applies both before the first beat and between beats.
- R6: After the last beat there is a recovery cycle that lasts until an edge with `busRdy` high. The next address phase can follow directly, so with no wait states two queued four-word 32-bit bursts start exactly six cycles apart.
- R7: On a narrow region the lowest-addressed byte(s) of a word go first. Each beat uses the low lanes only (bits 7:0 for 8-bit, 15:0 for 16-bit), and the unused upper lanes are driven zero on writes and ignored on reads.
- R8: With `bigEndian` low, the byte at word offset k is word bits [8k+7:8k]. With `bigEndian` high, it is bits [31-8k:24-8k]. Address byte k of a beat goes on lane k, counted from the first byte of that beat.
- R9: For reads, `rspValid` pulses for one cycle, the cycle after the edge that completes the last beat of each word. `rspData` then holds the reassembled word.
- R10: `busAdOe` is high in data phases only for writes, and `busWrite` is high during the address and data phases of a write cycle.
- R11: After reset `busAle`, `busAdOe`, `busWrite`, `rspValid` and `reqFull` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Core presents a request |
| reqWrite | input | 1 | Request is a write |
| reqAddr | input | 32 | Start address of the request |
| reqLen | input | 2 | Number of words minus one |
| reqWdata | input | 128 | Write words, word 0 in bits 31:0 |
| reqFull | output | 1 | Queue holds three requests |
| regionWidth | input | 16 | 2-bit width code per region |
| bigEndian | input | 1 | Byte order select |
| busAle | output | 1 | Address latch strobe |
| busAdOut | output | 32 | Multiplexed address/data driven out |
| busAdOe | output | 1 | Output enable for the shared pins |
| busAdIn | input | 32 | Multiplexed pins sampled in |
| busWrite | output | 1 | Current bus cycle is a write |
| busRdy | input | 1 | External ready |
| rspValid | output | 1 | Read word returned |
| rspData | output | 32 | Returned read word |

## Verification
When the controller is idle, a request accepted on one edge produces the address strobe in the second cycle after that edge. Write data for each beat appears in the cycle after the address phase and stays put until the edge where ready is high. The read word is due in the cycle after the edge that completes that word's last beat, and the next strobe follows the edge that ends recovery. The bench drives ready and read data at falling edges and samples every output at the following falling edge. This keeps each check one known number of edges after its stimulus, and wait states are added by holding ready low for a counted number of falling edges.

// File: rtl/mbb_pkg.sv
package mbb_pkg;
  localparam int WORD_W = 32;
  localparam int BYTES  = WORD_W / 8;

  typedef enum logic [1:0] {
    WID8  = 2'b00,
    WID16 = 2'b01,
    WID32 = 2'b10,
    WIDX  = 2'b11
  } widthCode_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_RECOV
  } busState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic aleOn;
    logic dataPhase;
    logic beatDone;
  } busStrobe_t;

  function automatic logic [WORD_W-1:0] swapBytes(input logic [WORD_W-1:0] w);
    logic [WORD_W-1:0] r;
    for (int k = 0; k < BYTES; k++) r[8*k +: 8] = w[8*(BYTES-1-k) +: 8];
    return r;
  endfunction
endpackage

// File: rtl/mbb_req_fifo.sv
module mbb_req_fifo #(
  parameter int ENTRY_W = 8,
  parameter int DEPTH   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               pushEn,
  input  logic [ENTRY_W-1:0] pushData,
  input  logic               popEn,
  output logic [ENTRY_W-1:0] headData,
  output logic               isEmpty,
  output logic               isFull
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [ENTRY_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0]   wrPtr, rdPtr;
  logic [CNT_W-1:0]   count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign isEmpty  = (count == '0);
  assign isFull   = (count == CNT_W'(DEPTH));
  assign headData = slots[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn) slots[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushEn) wrPtr <= bump(wrPtr);
      if (popEn)  rdPtr <= bump(rdPtr);
      if (pushEn && !popEn)      count <= count + 1'b1;
      else if (popEn && !pushEn) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/mbb_ctrl.sv
module mbb_ctrl
  import mbb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       qEmpty,
  input  logic       busRdy,
  input  logic       lastBeat,
  output busStrobe_t strobe
);
  busState_e state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (!qEmpty) begin
          strobe.load = 1'b1;
          stateNext   = ST_ADDR;
        end
      end
      ST_ADDR: begin
        strobe.aleOn = 1'b1;
        stateNext    = ST_DATA;
      end
      ST_DATA: begin
        strobe.dataPhase = 1'b1;
        if (busRdy) begin
          strobe.beatDone = 1'b1;
          if (lastBeat) stateNext = ST_RECOV;
        end
      end
      ST_RECOV: begin
        if (busRdy) begin
          if (!qEmpty) begin
            strobe.load = 1'b1;
            stateNext   = ST_ADDR;
          end else begin
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end
endmodule

// File: rtl/mbb_datapath.sv
module mbb_datapath
  import mbb_pkg::*;
#(
  parameter int REGION_CNT = 8,
  parameter int MAX_WORDS  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  busStrobe_t                  strobe,
  input  logic                        headWrite,
  input  logic [WORD_W-1:0]           headAddr,
  input  logic [((MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1)-1:0] headLen,
  input  logic [MAX_WORDS*WORD_W-1:0] headData,
  input  logic [2*REGION_CNT-1:0]     regionWidth,
  input  logic                        bigEndian,
  input  logic [WORD_W-1:0]           busAdIn,
  output logic                        lastBeat,
  output logic                        busAle,
  output logic [WORD_W-1:0]           busAdOut,
  output logic                        busAdOe,
  output logic                        busWrite,
  output logic                        rspValid,
  output logic [WORD_W-1:0]           rspData
);
  localparam int RBITS = (REGION_CNT > 1) ? $clog2(REGION_CNT) : 1;
  localparam int LEN_W = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;

  logic                        curWrite, curBig;
  logic [WORD_W-1:0]           curAddr;
  logic [LEN_W-1:0]            curLen, wordIdx;
  logic [1:0]                  curLog, beatIdx;
  logic [MAX_WORDS*WORD_W-1:0] curData;
  logic [WORD_W-1:0]           asmReg, asmNext;

  logic [RBITS-1:0]  headRegion;
  logic [1:0]        headCode, headLog;
  logic              lastInWord;
  logic [WORD_W-1:0] curWord, ordered, laneOut, laneMask;
  logic [1:0]        byteOff;
  logic [4:0]        laneShift;

  // region width lookup from the top address bits
  assign headRegion = headAddr[WORD_W-1 -: RBITS];
  assign headCode   = regionWidth[{headRegion, 1'b0} +: 2];
  always_comb begin
    case (headCode)
      WID8:    headLog = 2'd0;
      WID16:   headLog = 2'd1;
      default: headLog = 2'd2;
    endcase
  end

  assign lastInWord = (beatIdx == (2'd3 >> curLog));
  assign lastBeat   = lastInWord && (wordIdx == curLen);

  // write lane steering
  assign curWord   = curData[wordIdx*WORD_W +: WORD_W];
  assign ordered   = curBig ? swapBytes(curWord) : curWord;
  assign byteOff   = beatIdx << curLog;
  assign laneShift = {byteOff, 3'b000};
  always_comb begin
    case (curLog)
      2'd0:    laneMask = 32'h0000_00FF;
      2'd1:    laneMask = 32'h0000_FFFF;
      default: laneMask = '1;
    endcase
  end
  assign laneOut = (ordered >> laneShift) & laneMask;

  // read reassembly: each byte of the word belongs to one beat and one lane
  always_comb begin
    asmNext = asmReg;
    for (int k = 0; k < BYTES; k++) begin
      if ((k >> curLog) == int'(beatIdx))
        asmNext[8*k +: 8] = busAdIn[8*(k & ((1 << curLog) - 1)) +: 8];
    end
  end

  assign busAle   = strobe.aleOn;
  assign busAdOe  = strobe.aleOn | (strobe.dataPhase & curWrite);
  assign busWrite = curWrite & (strobe.aleOn | strobe.dataPhase);
  assign busAdOut = strobe.aleOn ? curAddr :
                    (strobe.dataPhase && curWrite) ? laneOut : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWrite <= 1'b0;
      curBig   <= 1'b0;
      curAddr  <= '0;
      curLen   <= '0;
      curLog   <= 2'd2;
      curData  <= '0;
      wordIdx  <= '0;
      beatIdx  <= '0;
      asmReg   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      rspValid <= 1'b0;
      if (strobe.load) begin
        curWrite <= headWrite;
        curBig   <= bigEndian;
        curAddr  <= headAddr;
        curLen   <= headLen;
        curLog   <= headLog;
        curData  <= headData;
        wordIdx  <= '0;
        beatIdx  <= '0;
      end else if (strobe.beatDone) begin
        asmReg <= asmNext;
        if (lastInWord) begin
          beatIdx <= '0;
          wordIdx <= wordIdx + 1'b1;
          if (!curWrite) begin
            rspValid <= 1'b1;
            rspData  <= curBig ? swapBytes(asmNext) : asmNext;
          end
        end else begin
          beatIdx <= beatIdx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mbb_bus_ctrl.sv
module mbb_bus_ctrl
  import mbb_pkg::*;
#(
  parameter int QUEUE_DEPTH = 3,
  parameter int REGION_CNT  = 8,
  parameter int MAX_WORDS   = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic                        reqWrite,
  input  logic [31:0]                 reqAddr,
  input  logic [((MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1)-1:0] reqLen,
  input  logic [MAX_WORDS*32-1:0]     reqWdata,
  output logic                        reqFull,
  input  logic [2*REGION_CNT-1:0]     regionWidth,
  input  logic                        bigEndian,
  output logic                        busAle,
  output logic [31:0]                 busAdOut,
  output logic                        busAdOe,
  input  logic [31:0]                 busAdIn,
  output logic                        busWrite,
  input  logic                        busRdy,
  output logic                        rspValid,
  output logic [31:0]                 rspData
);
  localparam int LEN_W   = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1;
  localparam int DATA_TW = MAX_WORDS * WORD_W;
  localparam int ENTRY_W = 1 + WORD_W + LEN_W + DATA_TW;

  logic [ENTRY_W-1:0] headEntry;
  logic               qEmpty, qFull, lastBeat;
  busStrobe_t         strobe;

  mbb_req_fifo #(.ENTRY_W(ENTRY_W), .DEPTH(QUEUE_DEPTH)) fifo_i (
    .clk(clk), .rstN(rstN),
    .pushEn(reqValid && !qFull),
    .pushData({reqWrite, reqAddr, reqLen, reqWdata}),
    .popEn(strobe.load),
    .headData(headEntry),
    .isEmpty(qEmpty),
    .isFull(qFull)
  );

  mbb_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .qEmpty(qEmpty), .busRdy(busRdy),
    .lastBeat(lastBeat), .strobe(strobe)
  );

  mbb_datapath #(.REGION_CNT(REGION_CNT), .MAX_WORDS(MAX_WORDS)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .headWrite(headEntry[ENTRY_W-1]),
    .headAddr(headEntry[ENTRY_W-2 -: WORD_W]),
    .headLen(headEntry[DATA_TW +: LEN_W]),
    .headData(headEntry[DATA_TW-1:0]),
    .regionWidth(regionWidth), .bigEndian(bigEndian), .busAdIn(busAdIn),
    .lastBeat(lastBeat), .busAle(busAle), .busAdOut(busAdOut),
    .busAdOe(busAdOe), .busWrite(busWrite),
    .rspValid(rspValid), .rspData(rspData)
  );

  assign reqFull = qFull;
endmodule

// File: rtl/mbb_bus_chk.sv
module mbb_bus_chk #(
  parameter int REGION_CNT = 8
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    reqFull,
  input logic [2*REGION_CNT-1:0] regionWidth,
  input logic                    busAle,
  input logic [31:0]             busAdOut,
  input logic                    busAdOe,
  input logic                    busWrite,
  input logic                    rspValid
);
  localparam int RBITS = (REGION_CNT > 1) ? $clog2(REGION_CNT) : 1;

  logic [1:0]       capWidth;
  logic [RBITS-1:0] aleRegion;
  assign aleRegion = busAdOut[31 -: RBITS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       capWidth <= 2'b10;
    else if (busAle) capWidth <= regionWidth[{aleRegion, 1'b0} +: 2];
  end

  // R2: the strobe lasts one clock
  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |=> !busAle);

  // R2: address is driven while the strobe is high
  p_ale_drives_r2: assert property (@(posedge clk) disable iff (!rstN)
    busAle |-> busAdOe);

  // R10: reads never drive the pins after the address phase
  p_read_no_drive_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && !busAle) |-> !busAdOe);

  // R9: a read word never arrives with an address phase or driven pins
  p_rsp_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (!busAle && !busAdOe));

  // R7: 8-bit region writes keep upper lanes zero
  p_lanes8_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAdOe && !busAle && capWidth == 2'b00) |-> (busAdOut[31:8] == 24'h0));

  // R7: 16-bit region writes keep upper lanes zero
  p_lanes16_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busAdOe && !busAle && capWidth == 2'b01) |-> (busAdOut[31:16] == 16'h0));

  // R1: a full queue does not drain while a write is on the data pins
  p_full_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    (reqFull && busAdOe && !busAle) |=> (reqFull || !busWrite || busAle || !busAdOe));
endmodule

bind mbb_bus_ctrl mbb_bus_chk #(.REGION_CNT(REGION_CNT)) chk_i (
  .clk(clk), .rstN(rstN), .reqFull(reqFull), .regionWidth(regionWidth),
  .busAle(busAle), .busAdOut(busAdOut), .busAdOe(busAdOe),
  .busWrite(busWrite), .rspValid(rspValid)
);

// File: tb/mbb_bus_ctrl_tb.sv
module mbb_bus_ctrl_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [31:0]  reqAddr = '0;
  logic [1:0]   reqLen = '0;
  logic [127:0] reqWdata = '0;
  logic         reqFull;
  logic [15:0]  regionWidth = 16'hAAC6; // r0=10 r1=01 r2=00 r3=11, rest 10
  logic         bigEndian = 1'b0;
  logic         busAle;
  logic [31:0]  busAdOut;
  logic         busAdOe;
  logic [31:0]  busAdIn = '0;
  logic         busWrite;
  logic         busRdy = 1'b1;
  logic         rspValid;
  logic [31:0]  rspData;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int aleCyc = 0;
  bit finished = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mbb_bus_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqLen(reqLen), .reqWdata(reqWdata), .reqFull(reqFull),
    .regionWidth(regionWidth), .bigEndian(bigEndian), .busAle(busAle),
    .busAdOut(busAdOut), .busAdOe(busAdOe), .busAdIn(busAdIn),
    .busWrite(busWrite), .busRdy(busRdy), .rspValid(rspValid), .rspData(rspData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // beat value per R7/R8: lowest address first on low lanes
  function automatic logic [31:0] mkBeat(input logic [31:0] w, input bit be,
                                         input int lg, input int j);
    logic [31:0] s;
    s = be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    case (lg)
      0:       return {24'h0, s[8*j +: 8]};
      1:       return {16'h0, s[16*j +: 16]};
      default: return s;
    endcase
  endfunction

  task automatic push(input bit wr, input logic [31:0] addr, input int nWords,
                      input logic [127:0] data);
    while (reqFull) @(negedge clk);
    reqValid = 1'b1;
    reqWrite = wr;
    reqAddr  = addr;
    reqLen   = 2'(nWords - 1);
    reqWdata = data;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // follows one bus cycle from its strobe to the end of recovery
  task automatic doBurst(input bit wr, input logic [31:0] addr, input int nWords,
                         input int lg, input bit be, input logic [127:0] data,
                         input int waitA, input int waitD, input int waitR,
                         input string tag);
    int guard = 0;
    int bpw = 4 >> lg;
    int nb = nWords * bpw;
    while (!busAle && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    check(busAle === 1'b1 && busAdOe === 1'b1, "R2", {tag, " strobe/oe"},
          {30'h0, busAle, busAdOe}, 32'h3);
    check(busAdOut === addr, "R2", {tag, " address"}, busAdOut, addr);
    check(busWrite === wr, "R10", {tag, " direction"}, {31'h0, busWrite}, {31'h0, wr});
    aleCyc = cyc;
    @(negedge clk);
    for (int b = 0; b < nb; b++) begin
      int w = b / bpw;
      int j = b % bpw;
      int nw = (b == 0) ? waitA : waitD;
      logic [31:0] bv = mkBeat(data[32*w +: 32], be, lg, j);
      for (int i = 0; i <= nw; i++) begin
        if (wr) begin
          check(busAdOe === 1'b1 && busAdOut === bv, "R5", {tag, " write beat"}, busAdOut, bv);
        end else begin
          check(busAdOe === 1'b0, "R10", {tag, " read no drive"}, {31'h0, busAdOe}, 32'h0);
        end
        check(busAle === 1'b0, "R4", {tag, " no strobe in data"}, {31'h0, busAle}, 32'h0);
        busRdy = (i == nw);
        busAdIn = (lg == 0) ? (bv | 32'hA5A5_A500) : (lg == 1) ? (bv | 32'hC3C3_0000) : bv;
        @(negedge clk);
      end
      if (!wr) begin
        if (j == bpw - 1) begin
          check(rspValid === 1'b1, "R9", {tag, " rsp valid"}, {31'h0, rspValid}, 32'h1);
          check(rspData === data[32*w +: 32], "R9", {tag, " rsp data"}, rspData, data[32*w +: 32]);
        end else begin
          check(rspValid === 1'b0, "R9", {tag, " no early rsp"}, {31'h0, rspValid}, 32'h0);
        end
      end
    end
    for (int i = 0; i < waitR; i++) begin
      busRdy = 1'b0;
      @(negedge clk);
      check(busAle === 1'b0 && busAdOe === 1'b0, "R6", {tag, " recovery held"},
            {30'h0, busAle, busAdOe}, 32'h0);
    end
    busRdy = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(busAle === 1'b0 && busAdOe === 1'b0 && busWrite === 1'b0, "R11", "bus idle",
          {29'h0, busAle, busAdOe, busWrite}, 32'h0);
    check(rspValid === 1'b0 && reqFull === 1'b0, "R11", "status low",
          {30'h0, rspValid, reqFull}, 32'h0);
  endtask

  task automatic t_first_strobe();
    bigEndian = 1'b0;
    push(1'b1, 32'h0000_0100, 1, {96'h0, 32'hDEAD_BEEF});
    check(busAle === 1'b0, "R2", "strobe not yet", {31'h0, busAle}, 32'h0);
    @(negedge clk);
    check(busAle === 1'b1, "R2", "strobe second cycle", {31'h0, busAle}, 32'h1);
    doBurst(1'b1, 32'h0000_0100, 1, 2, 1'b0, {96'h0, 32'hDEAD_BEEF}, 0, 0, 0, "first");
  endtask

  task automatic t_best_case();
    int firstAle;
    logic [127:0] d1 = 128'h4444_4444_3333_3333_2222_2222_1111_1111;
    logic [127:0] d2 = 128'h0D0D_0D0D_0C0C_0C0C_0B0B_0B0B_0A0A_0A0A;
    push(1'b1, 32'h0000_0200, 4, d1);
    push(1'b1, 32'h0000_0300, 4, d2);
    doBurst(1'b1, 32'h0000_0200, 4, 2, 1'b0, d1, 0, 0, 0, "R4 best1");
    firstAle = aleCyc;
    doBurst(1'b1, 32'h0000_0300, 4, 2, 1'b0, d2, 0, 0, 0, "R4 best2");
    check(aleCyc - firstAle == 6, "R6", "back-to-back spacing", 32'(aleCyc - firstAle), 32'd6);
  endtask

  task automatic t_narrow_write_be();
    logic [127:0] d = {64'h0, 32'hA1B2_C3D4, 32'h1122_3344};
    bigEndian = 1'b1;
    // R3 region 2 code 00: 8-bit, two words give eight beats
    push(1'b1, 32'h4000_0080, 2, d);
    doBurst(1'b1, 32'h4000_0080, 2, 0, 1'b1, d, 2, 1, 0, "R3 R7 R8 w8be");
    // R3 region 3 code 11: full width
    push(1'b1, 32'h6000_0010, 1, {96'h0, 32'h0102_0304});
    doBurst(1'b1, 32'h6000_0010, 1, 2, 1'b1, {96'h0, 32'h0102_0304}, 0, 0, 1, "R3 w32code11");
    bigEndian = 1'b0;
  endtask

  task automatic t_read16();
    logic [127:0] d = {32'h0, 32'h9988_7766, 32'h5544_3322, 32'hCAFE_F00D};
    bigEndian = 1'b0;
    push(1'b0, 32'h2000_0040, 3, d);
    doBurst(1'b0, 32'h2000_0040, 3, 1, 1'b0, d, 1, 2, 2, "R5 R9 r16le");
  endtask

  task automatic t_read32_be();
    logic [127:0] d = {64'h0, 32'h0BAD_F00D, 32'h1234_5678};
    bigEndian = 1'b1;
    push(1'b0, 32'h0000_0400, 2, d);
    doBurst(1'b0, 32'h0000_0400, 2, 2, 1'b1, d, 0, 1, 0, "R8 r32be");
    bigEndian = 1'b0;
  endtask

  task automatic t_read8_le();
    logic [127:0] d = {96'h0, 32'h8765_4321};
    push(1'b0, 32'h4000_0004, 1, d);
    doBurst(1'b0, 32'h4000_0004, 1, 0, 1'b0, d, 0, 0, 0, "R7 r8le");
  endtask

  task automatic t_queue_full();
    busRdy = 1'b0;
    push(1'b1, 32'h0000_1000, 1, {96'h0, 32'hAAAA_0001});
    push(1'b1, 32'h0000_2000, 1, {96'h0, 32'hAAAA_0002});
    push(1'b1, 32'h0000_3000, 1, {96'h0, 32'hAAAA_0003});
    push(1'b1, 32'h0000_4000, 1, {96'h0, 32'hAAAA_0004});
    check(reqFull === 1'b1, "R1", "full at three", {31'h0, reqFull}, 32'h1);
    busRdy = 1'b0;
    @(negedge clk);
    check(reqFull === 1'b1, "R1", "full while stalled", {31'h0, reqFull}, 32'h1);
    busRdy = 1'b1;
    @(negedge clk);
    check(reqFull === 1'b1, "R1", "full in recovery", {31'h0, reqFull}, 32'h1);
    @(negedge clk);
    check(reqFull === 1'b0, "R1", "frees after pop", {31'h0, reqFull}, 32'h0);
    doBurst(1'b1, 32'h0000_2000, 1, 2, 1'b0, {96'h0, 32'hAAAA_0002}, 0, 0, 0, "R1 order2");
    doBurst(1'b1, 32'h0000_3000, 1, 2, 1'b0, {96'h0, 32'hAAAA_0003}, 0, 0, 0, "R1 order3");
    doBurst(1'b1, 32'h0000_4000, 1, 2, 1'b0, {96'h0, 32'hAAAA_0004}, 0, 0, 0, "R1 order4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_strobe();
    t_best_case();
    t_narrow_write_be();
    t_read16();
    t_read32_be();
    t_read8_le();
    t_queue_full();
    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule